// File: doc/BRIEF.md
# Double-Buffered DAC Register Front End

This block sits between a 16-bit parallel host bus and a digital-to-analog converter core. It holds two register stages for the conversion word and for a 3-bit output-range code. A host loads the first stage through a write strobe, with a select line choosing the word or the range code. It then moves both values into the active stage with an update strobe. The active values drive the converter. Readback of either stage returns on the same bus lines. A clear loads the code that gives 0 V in the present range. A manual-range mode takes the range from three hard-wired pins.

All control pins and the bus are sampled on one system clock through a two-flop synchronizer. Strobes act on their synchronized levels. Holding write low and update high makes both stages flow through. Tying write and update to one host clock gives master-slave loading: the first stage follows the bus while the clock is low, and the active stage takes it when the clock rises. A rising update also raises a one-cycle trigger for the external output deglitcher.

Top module: `dacfe_top`

## Requirements
- R1: With read low, select low and write low, the data input register follows the full bus word.
- R2: With read low, select high and write low (programmable mode), the span input register loads bus bits 2..0. The other bus bits are ignored.
- R3: With read low, update high copies both input registers into the active data and span registers. Without update the active registers hold. Repeating an update with no new write leaves them unchanged.
- R4: Write low with update high makes both stages transparent, so a new bus word reaches the active data output.
- R5: With write and update driven together, the active data register holds the bus value present just before the rising edge. Later bus changes while high do not reach it.
- R6: Read high ignores the write strobe and the update strobe's copy. Update low selects the input stage for readback and update high selects the active stage. Select chooses data (all 16 bits) or span (bits 2..0, upper bits zero). The output enable is high only while reading a permitted source.
- R7: Each rising edge of update while read is low gives exactly one clock cycle of deglitch pulse. A rising edge while read is high gives none.
- R8: Clear loads both data registers with the 0 V code of the active span and leaves both span registers unchanged. Clear wins over a same-cycle write or update.
- R9: The span encoding is 000 = 0..5 V, 001 = 0..10 V, 010 = ±5 V, 011 = ±10 V, 100 = ±2.5 V, 101 = −2.5..7.5 V, and 110/111 behave as 0..5 V. The 0 V code is 0x0000 for the unipolar codes, 0x8000 for 010/011/100, and 0x4000 for 101. It is also shown on the zero-code output.
- R10: After power-on reset in programmable mode, the active span is 000, the active data is 0x0000 and the output enable is low.
- R11: In manual mode the span pins drive the active span at once. Span writes have no effect. Span readback keeps the output enable low. After reset the active data holds the 0 V code of the pin span.
- R12: Inputs pass two synchronizer flops. A write reaches the input register on the third rising edge after the bus and strobe change. In transparent mode the active data changes on the fourth.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| bus_in | input | 16 | Host bus, write direction |
| bus_out | output | 16 | Readback value, zero when not driven |
| bus_oe | output | 1 | High when bus_out should drive the bus |
| sel_span | input | 1 | 0 selects data word, 1 selects span code |
| wr_n | input | 1 | Write strobe, active low, level sensitive |
| upd | input | 1 | Update strobe, active high; readback stage select while reading |
| rd | input | 1 | Read request, active high |
| clr_n | input | 1 | Clear to 0 V code, active low |
| manual_span | input | 1 | 1 selects hard-wired span mode |
| span_pins | input | 3 | Hard-wired span code for manual mode |
| dac_data | output | 16 | Active data word to the converter |
| dac_span | output | 3 | Active span code to the converter |
| zero_code | output | 16 | 0 V code for the active span |
| dgl_pulse | output | 1 | One-cycle deglitch trigger |

## Verification
Clear and update can act in the same cycle. The bench shows this by writing a new data word and a bipolar span, then lowering clear and raising update together. The active span must take the new code while both data registers end at the 0 V code of that new span, not the written word. A second case holds write low during clear and checks that the written value never appears. Each span code, including the unused ones, is swept through clear so every 0 V code is compared against an arithmetic expectation.

// File: rtl/dacfe_pkg.sv
`timescale 1ns/1ps
package dacfe_pkg;

   localparam int SPAN_W = 3;

   typedef enum logic [SPAN_W-1:0] {
      RNG_UNI5   = 3'd0,
      RNG_UNI10  = 3'd1,
      RNG_BIP5   = 3'd2,
      RNG_BIP10  = 3'd3,
      RNG_BIP2P5 = 3'd4,
      RNG_OFFSET = 3'd5
   } range_e;

   typedef struct packed {
      logic rd;
      logic upd;
      logic wr_n;
      logic sel;
      logic clr_n;
   } ctrl_t;

   // read idle, write idle, clear asserted: forces a clear right after reset
   localparam ctrl_t CTRL_RST = '{rd: 1'b0, upd: 1'b0, wr_n: 1'b1, sel: 1'b0, clr_n: 1'b0};

endpackage

// File: rtl/dacfe_sync.sv
`timescale 1ns/1ps
module dacfe_sync #(
   parameter int             W       = 1,
   parameter int             STAGES  = 2,
   parameter logic [W-1:0]   RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (STAGES < 2) begin : g_bad_depth
      $error("dacfe_sync: STAGES must be at least 2");
   end
   if (W < 1) begin : g_bad_width
      $error("dacfe_sync: W must be positive");
   end

   logic [W-1:0] stage_q [STAGES];

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[0] <= RST_VAL;
            else        stage_q[0] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[i] <= RST_VAL;
            else        stage_q[i] <= stage_q[i-1];
         end
      end
   end

   assign q = stage_q[STAGES-1];

endmodule

// File: rtl/dacfe_zero_code.sv
`timescale 1ns/1ps
module dacfe_zero_code
   import dacfe_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  logic [SPAN_W-1:0] range_code,
   output logic [DATA_W-1:0] code
);

   if (DATA_W < 4) begin : g_bad_width
      $error("dacfe_zero_code: DATA_W must be at least 4");
   end

   localparam logic [DATA_W-1:0] MID_SCALE  = {1'b1,  {(DATA_W-1){1'b0}}};
   localparam logic [DATA_W-1:0] QTR_SCALE  = {2'b01, {(DATA_W-2){1'b0}}};
   localparam logic [DATA_W-1:0] ZERO_SCALE = '0;

   always_comb begin
      case (range_e'(range_code))
         RNG_BIP5, RNG_BIP10, RNG_BIP2P5: code = MID_SCALE;
         RNG_OFFSET:                      code = QTR_SCALE;
         default:                         code = ZERO_SCALE;
      endcase
   end

endmodule

// File: rtl/dacfe_reg_pair.sv
`timescale 1ns/1ps
module dacfe_reg_pair #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic [W-1:0] clr_val,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         copy,
   output logic [W-1:0] in_q,
   output logic [W-1:0] act_q
);

   if (W < 1) begin : g_bad_width
      $error("dacfe_reg_pair: W must be positive");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    in_q <= '0;
      else if (clr)  in_q <= clr_val;
      else if (load) in_q <= load_val;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    act_q <= '0;
      else if (clr)  act_q <= clr_val;
      else if (copy) act_q <= in_q;
   end

   a_r1_input_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !clr) |=> $stable(in_q));

   a_r3_active_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!copy && !clr) |=> $stable(act_q));

   a_r3_copy_through: assert property (@(posedge clk) disable iff (!rst_n)
      (copy && !clr) |=> (act_q == $past(in_q)));

   a_r8_clear_both: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (in_q == $past(clr_val) && act_q == $past(clr_val)));

endmodule

// File: rtl/dacfe_top.sv
`timescale 1ns/1ps
module dacfe_top
   import dacfe_pkg::*;
#(
   parameter int DATA_W      = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] bus_in,
   output logic [DATA_W-1:0] bus_out,
   output logic              bus_oe,
   input  logic              sel_span,
   input  logic              wr_n,
   input  logic              upd,
   input  logic              rd,
   input  logic              clr_n,
   input  logic              manual_span,
   input  logic [SPAN_W-1:0] span_pins,
   output logic [DATA_W-1:0] dac_data,
   output logic [SPAN_W-1:0] dac_span,
   output logic [DATA_W-1:0] zero_code,
   output logic              dgl_pulse
);

   localparam int CTRL_W = $bits(ctrl_t);
   localparam int PAD_W  = DATA_W - SPAN_W;

   if (DATA_W < SPAN_W + 1) begin : g_bad_width
      $error("dacfe_top: DATA_W must exceed the span width");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("dacfe_top: SYNC_STAGES must be at least 2");
   end

   // ---------------- input synchronization ----------------
   ctrl_t             ctrl_raw;
   logic [CTRL_W-1:0] ctrl_sync;
   ctrl_t             ctl;
   logic [DATA_W-1:0] bus_q;

   assign ctrl_raw = '{rd: rd, upd: upd, wr_n: wr_n, sel: sel_span, clr_n: clr_n};

   dacfe_sync #(.W(CTRL_W), .STAGES(SYNC_STAGES), .RST_VAL(CTRL_RST)) u_ctrl_sync (
      .clk(clk), .rst_n(rst_n), .d(ctrl_raw), .q(ctrl_sync)
   );
   assign ctl = ctrl_t'(ctrl_sync);

   dacfe_sync #(.W(DATA_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_bus_sync (
      .clk(clk), .rst_n(rst_n), .d(bus_in), .q(bus_q)
   );

   // ---------------- strobe decode ----------------
   logic wr_active, copy_en, clr_en;
   logic data_load, span_load;

   assign wr_active = !ctl.rd && !ctl.wr_n;
   assign copy_en   = !ctl.rd && ctl.upd;
   assign clr_en    = !ctl.clr_n;
   assign data_load = wr_active && !ctl.sel;
   assign span_load = wr_active && ctl.sel && !manual_span;

   // ---------------- register stages ----------------
   logic [SPAN_W-1:0] span_in_q, span_act_q, span_eff;
   logic [DATA_W-1:0] data_in_q, data_act_q, zc;

   dacfe_reg_pair #(.W(SPAN_W)) u_span_regs (
      .clk(clk), .rst_n(rst_n),
      .clr(1'b0), .clr_val('0),
      .load(span_load), .load_val(bus_q[SPAN_W-1:0]),
      .copy(copy_en),
      .in_q(span_in_q), .act_q(span_act_q)
   );

   assign span_eff = manual_span ? span_pins : span_act_q;

   dacfe_zero_code #(.DATA_W(DATA_W)) u_zero (
      .range_code(span_eff), .code(zc)
   );

   dacfe_reg_pair #(.W(DATA_W)) u_data_regs (
      .clk(clk), .rst_n(rst_n),
      .clr(clr_en), .clr_val(zc),
      .load(data_load), .load_val(bus_q),
      .copy(copy_en),
      .in_q(data_in_q), .act_q(data_act_q)
   );

   // ---------------- deglitch trigger ----------------
   logic upd_prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         upd_prev  <= 1'b0;
         dgl_pulse <= 1'b0;
      end else begin
         upd_prev  <= ctl.upd;
         dgl_pulse <= ctl.upd && !upd_prev && !ctl.rd;
      end
   end

   a_r7_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
      dgl_pulse |=> !dgl_pulse);

   // ---------------- readback ----------------
   logic [DATA_W-1:0] rb_data, rb_span;

   assign rb_data = ctl.upd ? data_act_q : data_in_q;
   assign rb_span = {{PAD_W{1'b0}}, (ctl.upd ? span_act_q : span_in_q)};
   assign bus_oe  = ctl.rd && !(ctl.sel && manual_span);

   always_comb begin
      if (!bus_oe)      bus_out = '0;
      else if (ctl.sel) bus_out = rb_span;
      else              bus_out = rb_data;
   end

   // ---------------- converter side ----------------
   assign dac_data  = data_act_q;
   assign dac_span  = span_eff;
   assign zero_code = zc;

endmodule

// File: tb/dacfe_top_test.sv
`timescale 1ns/1ps
module dacfe_top_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] bus_in = '0;
   logic [15:0] bus_out;
   logic        bus_oe;
   logic        sel_span = 1'b0;
   logic        wr_n = 1'b1;
   logic        upd = 1'b0;
   logic        rd = 1'b0;
   logic        clr_n = 1'b1;
   logic        manual_span = 1'b0;
   logic [2:0]  span_pins = 3'd0;
   logic [15:0] dac_data;
   logic [2:0]  dac_span;
   logic [15:0] zero_code;
   logic        dgl_pulse;

   int n_checks = 0;
   int n_fail   = 0;
   int pulses   = 0;

   always #4 clk = ~clk;

   dacfe_top uut (
      .clk(clk), .rst_n(rst_n), .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe),
      .sel_span(sel_span), .wr_n(wr_n), .upd(upd), .rd(rd), .clr_n(clr_n),
      .manual_span(manual_span), .span_pins(span_pins),
      .dac_data(dac_data), .dac_span(dac_span), .zero_code(zero_code), .dgl_pulse(dgl_pulse)
   );

   always @(posedge clk) if (rst_n && dgl_pulse) pulses++;

   function automatic logic [15:0] exp_zero(input logic [2:0] c);
      case (c)
         3'd2, 3'd3, 3'd4: return 16'h1 << 15;
         3'd5:             return 16'h1 << 14;
         default:          return 16'h0;
      endcase
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic do_reset();
      rst_n = 1'b0; wr_n = 1'b1; upd = 1'b0; rd = 1'b0; clr_n = 1'b1; sel_span = 1'b0;
      tick(3);
      rst_n = 1'b1;
      tick(6);
   endtask

   task automatic wr_data(input logic [15:0] v);
      sel_span = 1'b0; bus_in = v; wr_n = 1'b0; tick(4);
      wr_n = 1'b1; tick(4);
   endtask

   task automatic wr_span(input logic [2:0] c);
      sel_span = 1'b1; bus_in = 16'hFFF8 | {13'd0, c}; wr_n = 1'b0; tick(4);
      wr_n = 1'b1; tick(4);
      sel_span = 1'b0; tick(1);
   endtask

   task automatic do_upd();
      upd = 1'b1; tick(4);
      upd = 1'b0; tick(4);
   endtask

   task automatic do_clear();
      clr_n = 1'b0; tick(4);
      clr_n = 1'b1; tick(4);
   endtask

   task automatic read_back(input logic want_span, input logic active,
                            output logic [15:0] v, output logic oe);
      rd = 1'b1; sel_span = want_span; tick(4);
      if (active) begin upd = 1'b1; tick(4); end
      v = bus_out; oe = bus_oe;
      upd = 1'b0; tick(4);
      rd = 1'b0; tick(4);
      sel_span = 1'b0; tick(1);
   endtask

   initial begin : watchdog
      #(8 * 150000);
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
   end

   initial begin : main
      logic [15:0] v;
      logic        oe;
      int          p0;
      logic [15:0] pats [5];
      pats[0] = 16'h1234; pats[1] = 16'hFFFF; pats[2] = 16'hA5A5;
      pats[3] = 16'h0001; pats[4] = 16'h8000;

      do_reset();
      chk("R10 data", dac_data, 16'h0);
      chk("R10 span", dac_span, 3'd0);
      chk("R10 oe", bus_oe, 1'b0);
      chk("R9 zero code at reset", zero_code, 16'h0);

      // R1 / R3 / R7 data pattern sweep
      for (int i = 0; i < 5; i++) begin
         logic [15:0] prev;
         prev = dac_data;
         wr_data(pats[i]);
         read_back(1'b0, 1'b0, v, oe);
         chk("R1 input readback", v, pats[i]);
         chk("R6 data oe", oe, 1'b1);
         chk("R3 active holds before update", dac_data, prev);
         p0 = pulses;
         do_upd();
         chk("R3 update copies", dac_data, pats[i]);
         chk("R7 one pulse", pulses - p0, 1);
      end

      // R3 repeat update without a write
      do_upd();
      chk("R3 repeat update", dac_data, 16'h8000);

      // R2 / R8 / R9 span sweep with clear
      for (int c = 0; c < 8; c++) begin
         wr_span(c[2:0]);
         read_back(1'b1, 1'b0, v, oe);
         chk("R2 span input readback", v, {13'd0, c[2:0]});
         wr_data(16'h1357);
         do_upd();
         chk("R3 span active", dac_span, c[2:0]);
         chk("R9 zero code output", zero_code, exp_zero(c[2:0]));
         do_clear();
         chk("R8 active data cleared", dac_data, exp_zero(c[2:0]));
         read_back(1'b0, 1'b0, v, oe);
         chk("R8 input data cleared", v, exp_zero(c[2:0]));
         read_back(1'b1, 1'b1, v, oe);
         chk("R8 active span kept", v, {13'd0, c[2:0]});
         read_back(1'b1, 1'b0, v, oe);
         chk("R8 input span kept", v, {13'd0, c[2:0]});
      end

      // R6 read ignores write, readback of both stages
      wr_span(3'd0); do_upd();
      wr_data(16'h2468); do_upd();
      wr_data(16'h1111);
      rd = 1'b1; tick(4);
      sel_span = 1'b0; bus_in = 16'hDEAD; wr_n = 1'b0; tick(4);
      wr_n = 1'b1; tick(4);
      rd = 1'b0; tick(4);
      read_back(1'b0, 1'b0, v, oe);
      chk("R6 write ignored under read", v, 16'h1111);
      p0 = pulses;
      read_back(1'b0, 1'b1, v, oe);
      chk("R6 active readback", v, 16'h2468);
      chk("R7 no pulse while reading", pulses - p0, 0);
      chk("R6 update ignored under read", dac_data, 16'h2468);
      chk("R6 oe idle", bus_oe, 1'b0);

      // R4 transparent and R12 latency
      bus_in = 16'h0F0F; sel_span = 1'b0; wr_n = 1'b0; upd = 1'b1; tick(6);
      chk("R4 transparent A", dac_data, 16'h0F0F);
      bus_in = 16'hF0F0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R12 not yet after three edges", dac_data, 16'h0F0F);
      @(posedge clk); @(negedge clk);
      chk("R12 arrives on fourth edge", dac_data, 16'hF0F0);
      wr_n = 1'b1; tick(4); upd = 1'b0; tick(4);

      // R5 master-slave
      wr_n = 1'b0; upd = 1'b0; bus_in = 16'h3333; tick(4);
      bus_in = 16'h4444; tick(4);
      wr_n = 1'b1; upd = 1'b1; tick(4);
      chk("R5 rising edge captures", dac_data, 16'h4444);
      bus_in = 16'h5555; tick(4);
      chk("R5 high phase holds", dac_data, 16'h4444);
      wr_n = 1'b0; upd = 1'b0; tick(4);
      chk("R5 low phase holds active", dac_data, 16'h4444);
      wr_n = 1'b1; upd = 1'b1; tick(4);
      chk("R5 next rising edge", dac_data, 16'h5555);
      upd = 1'b0; tick(4);

      // R8 clear and update together
      wr_span(3'd3);
      wr_data(16'h1357);
      clr_n = 1'b0; upd = 1'b1; tick(4);
      clr_n = 1'b1; tick(4);
      upd = 1'b0; tick(4);
      chk("R8 span updates beside clear", dac_span, 3'd3);
      chk("R8 clear beats update", dac_data, 16'h8000);
      // clear during a write
      sel_span = 1'b0; bus_in = 16'h7777; clr_n = 1'b0; wr_n = 1'b0; tick(4);
      wr_n = 1'b1; tick(4); clr_n = 1'b1; tick(4);
      read_back(1'b0, 1'b0, v, oe);
      chk("R8 clear beats write", v, 16'h8000);

      // R11 manual mode
      manual_span = 1'b1; span_pins = 3'd5;
      do_reset();
      chk("R11 reset data zero code", dac_data, 16'h4000);
      chk("R11 pin span", dac_span, 3'd5);
      wr_span(3'd3); do_upd();
      chk("R11 span write ignored", dac_span, 3'd5);
      read_back(1'b1, 1'b0, v, oe);
      chk("R11 span readback oe", oe, 1'b0);
      read_back(1'b0, 1'b0, v, oe);
      chk("R11 data readback oe", oe, 1'b1);
      span_pins = 3'd3; tick(1);
      chk("R11 pins drive span", dac_span, 3'd3);
      do_clear();
      chk("R11 clear uses pin span", dac_data, 16'h8000);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
   end

endmodule